// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block stores the general-purpose registers of a small processor datapath: fifteen words, each selected by a 4-bit identifier. Two read ports and one write port work independently, so an instruction can fetch two source operands and retire one result in the same clock cycle.

Reads are purely combinational. Each read port's output follows its identifier input with no clock involved. Writes are registered and take effect at the rising clock edge. The all-ones identifier (15) is a null register with no storage behind it. Using it on the write port performs no write. Using it on a read port drives zero. There is no forwarding path: a read of the register being written shows the old contents until the edge. An active-low asynchronous reset clears every register.

Top module: `reg_file_2r1w`

## Requirements
- R1: While reset is asserted, and after it is released with no write yet performed, reading any identifier 0 to 14 on either port returns zero.
- R2: A write with a destination identifier 0 to 14 stores the write data into that register at the rising clock edge. The new value is visible on the read ports right after that edge.
- R3: A write with destination identifier 15 changes no register. Every register read afterwards returns the value it held before that cycle.
- R4: Read port A drives the contents of the register named by its source identifier within the same cycle, with no clock edge needed.
- R5: Read port B behaves like port A and is independent of it. Both ports may name different registers or the same register.
- R6: A read port whose source identifier is 15 drives zero.
- R7: A read of the register being written in the same cycle returns the old value until the clock edge. There is no bypass.
- R8: Two reads and one write in the same cycle are all performed. Their results match an independent model over long random traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes occur on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all registers |
| src_a_i | input | 4 | Read port A identifier (15 = null) |
| val_a_o | output | 32 | Read port A data |
| src_b_i | input | 4 | Read port B identifier (15 = null) |
| val_b_o | output | 32 | Read port B data |
| dst_i | input | 4 | Write identifier (15 = no write) |
| wdata_i | input | 32 | Write data |

## Verification
The write and the reads can land in the same cycle and name the same register. This is the case where a missing or accidental bypass would show. The bench provokes it with directed cycles in which both read ports point at the destination. It compares the outputs before the edge against the old value in a shadow array, and after the edge against the new one. Random cycles then draw identifiers from a narrow range that includes 15, so that write/read collisions, same-register dual reads and null accesses recur often. Every combinational read is judged against the shadow before the shadow is updated at the edge.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_DATA_W = 32;
  localparam int RF_ID_W   = 4;

  // all-ones identifier of a given width is the null register
  function automatic logic is_null_id(input logic [RF_ID_W-1:0] id);
    return &id;
  endfunction
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int ID_W     = 4,
  parameter int NUM_REGS = (1 << ID_W) - 1
) (
  input  logic [ID_W-1:0]     dst_i,
  output logic [NUM_REGS-1:0] we_o
);
  // the null id matches no slot, so no enable fires
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign we_o[i] = (dst_i == ID_W'(i));
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 15
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_REGS-1:0]              we_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    regs_o[i] <= '0;
      else if (we_i[i]) regs_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int DATA_W   = 32,
  parameter int ID_W     = 4,
  parameter int NUM_REGS = (1 << ID_W) - 1
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [ID_W-1:0]                 src_i,
  output logic [DATA_W-1:0]               data_o
);
  // AND-OR select; the null id selects nothing and yields zero
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (src_i == ID_W'(i)) data_o = data_o | regs_i[i];
    end
  end
endmodule

// File: rtl/reg_file_2r1w.sv
module reg_file_2r1w
  import rf_pkg::*;
#(
  parameter int DATA_W = RF_DATA_W,
  parameter int ID_W   = RF_ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   src_a_i,
  output logic [DATA_W-1:0] val_a_o,
  input  logic [ID_W-1:0]   src_b_i,
  output logic [DATA_W-1:0] val_b_o,
  input  logic [ID_W-1:0]   dst_i,
  input  logic [DATA_W-1:0] wdata_i
);
  localparam int NUM_REGS = (1 << ID_W) - 1;
  localparam int NUM_RD   = 2;

  logic [NUM_REGS-1:0]             we;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_RD-1:0][ID_W-1:0]     rd_src;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

  assign rd_src[0] = src_a_i;
  assign rd_src[1] = src_b_i;
  assign val_a_o   = rd_data[0];
  assign val_b_o   = rd_data[1];

  rf_wr_decode #(.ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_dec (
    .dst_i (dst_i),
    .we_o  (we)
  );

  rf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_rd_port #(.DATA_W(DATA_W), .ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_rd (
      .regs_i (regs),
      .src_i  (rd_src[p]),
      .data_o (rd_data[p])
    );
  end
endmodule

// File: rtl/rf_2r1w_chk.sv
module rf_2r1w_chk #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ID_W-1:0]   src_a_i,
  input logic [DATA_W-1:0] val_a_o,
  input logic [ID_W-1:0]   src_b_i,
  input logic [DATA_W-1:0] val_b_o,
  input logic [ID_W-1:0]   dst_i,
  input logic [DATA_W-1:0] wdata_i
);
  localparam logic [ID_W-1:0] NULL_ID = '1;

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (val_a_o == '0 && val_b_o == '0));

  assert_write_visible_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_i != NULL_ID) |=> (src_a_i != $past(dst_i) || val_a_o == $past(wdata_i)));

  assert_null_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_i == NULL_ID) |=> (src_b_i != $past(src_b_i) || val_b_o == $past(val_b_o)));

  assert_same_reg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_a_i == src_b_i) |-> (val_a_o == val_b_o));

  assert_null_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_a_i == NULL_ID) |-> (val_a_o == '0));
endmodule

bind reg_file_2r1w rf_2r1w_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_a_i (src_a_i),
  .val_a_o (val_a_o),
  .src_b_i (src_b_i),
  .val_b_o (val_b_o),
  .dst_i   (dst_i),
  .wdata_i (wdata_i)
);

// File: tb/reg_file_2r1w_tb.sv
`timescale 1ns/1ps
module reg_file_2r1w_tb;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam logic [IW-1:0] NUL = 4'hF;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [IW-1:0] src_a = NUL, src_b = NUL, dst = NUL;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] val_a, val_b;

  logic [DW-1:0] shadow [15];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  reg_file_2r1w u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .src_a_i(src_a), .val_a_o(val_a),
    .src_b_i(src_b), .val_b_o(val_b),
    .dst_i(dst), .wdata_i(wdata)
  );

  function automatic logic [DW-1:0] exp_rd(input logic [IW-1:0] id);
    return (id == NUL) ? '0 : shadow[id];
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // set inputs after negedge, check combinational reads, then apply the edge
  task automatic step(input logic [IW-1:0] a, input logic [IW-1:0] b,
                      input logic [IW-1:0] d, input logic [DW-1:0] w, input string req);
    @(negedge clk);
    src_a = a; src_b = b; dst = d; wdata = w;
    #1;
    chk({req, " port A"}, val_a, exp_rd(a));
    chk({req, " port B"}, val_b, exp_rd(b));
    @(posedge clk);
    if (d != NUL) shadow[d] = w;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 16; i++) begin
      src_a = IW'(i); src_b = IW'(14 - (i % 15));
      #1;
      chk({req, " port A"}, val_a, exp_rd(IW'(i)));
      chk({req, " port B"}, val_b, exp_rd(IW'(14 - (i % 15))));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 15; i++) shadow[i] = '0;
    // R1: reads during reset, with a write request pending
    dst = 4'd2; wdata = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    read_all("R1 in reset");
    dst = NUL;
    rst_ni = 1'b1;
    @(negedge clk);
    read_all("R1 after reset");

    // R7 then R2: read the register being written
    step(4'd3, 4'd3, 4'd3, 32'h1234_5678, "R7 old value");
    step(4'd3, 4'd0, NUL, 32'h0, "R2 new value");
    step(4'd14, 4'd0, 4'd14, 32'hFFFF_0001, "R2 top reg write");
    step(4'd14, 4'd14, NUL, 32'hAAAA_5555, "R2 top reg read");
    // R3: null write with non-zero data
    step(4'd0, 4'd3, NUL, 32'hCAFE_F00D, "R3 null write");
    @(negedge clk);
    read_all("R3 all regs");
    // R6: null reads
    step(NUL, NUL, 4'd5, 32'h0BAD_0BAD, "R6 null read");
    step(NUL, 4'd5, NUL, 32'h0, "R6 null on A only");
    // R4/R5: change ids without a clock
    @(negedge clk);
    dst = NUL;
    for (int i = 0; i < 15; i++) begin
      src_a = IW'(i); src_b = IW'(14 - i);
      #0.5;
      chk("R4 comb read A", val_a, exp_rd(IW'(i)));
      chk("R5 comb read B", val_b, exp_rd(IW'(14 - i)));
    end
    // R8: random dual read + write, narrow id range to force collisions
    for (int n = 0; n < 3000; n++) begin
      logic [IW-1:0] a, b, d;
      a = (n % 2 == 0) ? IW'($urandom_range(11, 15)) : IW'($urandom_range(0, 15));
      b = IW'($urandom_range(11, 15));
      d = ($urandom_range(0, 3) == 0) ? a : IW'($urandom_range(11, 15));
      step(a, b, d, $urandom(), "R8 random");
    end
    @(negedge clk);
    read_all("R8 final");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule